// File: doc/BRIEF.md
# L2 Fill Sequencer

This block sits between the first-level instruction and data caches and an external second-level cache. It takes data-cache misses, instruction-cache misses and write-through stores, and turns each into a fixed series of 8-byte external accesses. A data miss becomes two read beats covering a 16-byte aligned block. An instruction miss becomes four read beats covering a 32-byte aligned block. A store becomes one write beat. The external cache can take no more than one access every two cycles, and the block keeps to that spacing for every kind of request.

Read data comes back a fixed number of cycles after each access. The block tags every returned beat with its source, its index within the line and a last-beat marker, so the requesting cache can build the line. Each data byte carries one even-parity bit. The block generates parity on write data and checks it on read data, and it raises an error flag with any beat whose parity does not match. A fill runs to its end once it has started. Between requests, a data miss wins over an instruction miss, and an instruction miss wins over a store. Stores do not wait for earlier stores to finish, so a steady stream of stores issues at the full external rate.

Top module: `l2fill_seq`

## Requirements
- R1: The block never drives `ext_en` high in two adjacent cycles.
- R2: A granted data miss produces two read beats at base and base+8, where base is `dmiss_addr` with its low 4 bits cleared, in that order.
- R3: A granted instruction miss produces four read beats at base, base+8, base+16 and base+24, where base is `imiss_addr` with its low 5 bits cleared, in that order.
- R4: A granted store produces one write beat with `ext_we`=1, address `st_addr` with its low 3 bits cleared, and data `st_data`. With only `st_req` held high, stores issue exactly every two cycles.
- R5: On every write beat, `ext_wpar[k]` equals the XOR of the eight bits of byte k of `ext_wdata`, where byte k is bits 8k+7..8k.
- R6: A grant is a one-cycle pulse in cycle t. Beat j of that request is on the external port in cycle t+1+2j. No grant is given until the cycle after the request's last beat.
- R7: When grants are possible, exactly one grant goes to the highest-priority pending request: data miss first, then instruction miss, then store.
- R8: The fill output for a read beat issued in cycle A is valid in cycle A+RD_LAT+1. It carries `fill_data` equal to the `ext_rdata` returned for that beat, `fill_src` (0 = data miss, 1 = instruction miss), `fill_idx` equal to the beat index j, and `fill_last` high only on the final beat.
- R9: `fill_perr` is high with a returned beat exactly when, for at least one byte k, the XOR of that byte of `ext_rdata` differs from `ext_rpar[k]`.
- R10: During reset, and in the cycles after reset before any request, `ext_en` and `fill_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dmiss_req | input | 1 | Data-cache miss pending; held until granted |
| dmiss_addr | input | ADDR_W | Byte address of the data miss |
| dmiss_gnt | output | 1 | Data miss accepted this cycle |
| imiss_req | input | 1 | Instruction-cache miss pending; held until granted |
| imiss_addr | input | ADDR_W | Byte address of the instruction miss |
| imiss_gnt | output | 1 | Instruction miss accepted this cycle |
| st_req | input | 1 | Store pending; held until granted |
| st_addr | input | ADDR_W | Byte address of the store |
| st_data | input | DATA_W | Store data, 8 bytes |
| st_gnt | output | 1 | Store accepted this cycle |
| ext_en | output | 1 | External access strobe |
| ext_we | output | 1 | External access is a write |
| ext_addr | output | ADDR_W | External 8-byte-aligned byte address |
| ext_wdata | output | DATA_W | External write data |
| ext_wpar | output | DATA_W/8 | Even parity per write byte |
| ext_rdata | input | DATA_W | External read data, RD_LAT cycles after the access |
| ext_rpar | input | DATA_W/8 | Parity bits returned with read data |
| fill_valid | output | 1 | Returned beat valid |
| fill_src | output | 1 | 0 = data miss, 1 = instruction miss |
| fill_idx | output | 2 | Beat index within the line |
| fill_last | output | 1 | Final beat of the line |
| fill_data | output | DATA_W | Returned beat data |
| fill_perr | output | 1 | Parity mismatch on this beat |

## Verification
The embedded assertions check, on every cycle, the two-cycle spacing of external accesses, the absence of grants while a fill is running, the priority order and one-hot form of the grants, the 8-byte steps between beats of one fill, and the index order and last-beat marker of returned beats. Only the bench scenarios can show end-to-end facts. These are the exact base address and alignment for each miss type, the written data and its parity, the return latency, that returned data matches the memory model, and that the error flag tracks injected parity faults. The bench also drives a saturated store stream, simultaneous requests of all three kinds, and a fully loaded random phase.

// File: rtl/l2fill_pkg.sv
package l2fill_pkg;

    // fill source encoding carried on the return path
    typedef enum logic {
        SRC_DATA = 1'b0,
        SRC_INST = 1'b1
    } fill_src_e;

    // even parity bit for one byte
    function automatic logic even_bit(input logic [7:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/l2fill_arb.sv
module l2fill_arb #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         open_i,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);

    // index 0 carries the highest priority
    always_comb begin
        logic taken;
        taken = !open_i;
        gnt_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !taken) begin
                gnt_o[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R7

    AST_ARB_GRANTS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i && (req_i != '0)) |-> (gnt_o != '0)); // R7

    for (genvar i = 1; i < N; i++) begin : g_prio
        AST_ARB_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_o[i] |-> (req_i[i-1:0] == '0)); // R7
    end

endmodule

// File: rtl/l2fill_issue.sv
module l2fill_issue #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int D_BEATS = 2,
    parameter int I_BEATS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                d_req,
    input  logic [ADDR_W-1:0]   d_addr,
    input  logic                i_req,
    input  logic [ADDR_W-1:0]   i_addr,
    input  logic                s_req,
    input  logic [ADDR_W-1:0]   s_addr,
    input  logic [DATA_W-1:0]   s_data,
    output logic                d_gnt,
    output logic                i_gnt,
    output logic                s_gnt,
    output logic                ext_en,
    output logic                ext_we,
    output logic [ADDR_W-1:0]   ext_addr,
    output logic [DATA_W-1:0]   ext_wdata,
    output logic [DATA_W/8-1:0] ext_wpar,
    output logic                tag_vld,
    output logic                tag_src,
    output logic [$clog2(I_BEATS)-1:0] tag_idx,
    output logic                tag_last
);

    localparam int BYTES   = DATA_W / 8;
    localparam int OFF_W   = $clog2(BYTES);
    localparam int IDX_W   = $clog2(I_BEATS);
    localparam int D_BLK   = D_BEATS * BYTES;
    localparam int I_BLK   = I_BEATS * BYTES;
    localparam logic [ADDR_W-1:0] D_MASK = ~ADDR_W'(D_BLK - 1);
    localparam logic [ADDR_W-1:0] I_MASK = ~ADDR_W'(I_BLK - 1);
    localparam logic [ADDR_W-1:0] S_MASK = ~ADDR_W'(BYTES - 1);
    localparam logic [IDX_W-1:0]  D_LAST = IDX_W'(D_BEATS - 1);
    localparam logic [IDX_W-1:0]  I_LAST = IDX_W'(I_BEATS - 1);

    typedef struct packed {
        logic               busy;
        logic               src;
        logic [IDX_W-1:0]   beat;
        logic [IDX_W-1:0]   last_idx;
        logic [ADDR_W-1:0]  base;
        logic               gap;
        logic               ext_en;
        logic               ext_we;
        logic [ADDR_W-1:0]  ext_addr;
        logic [DATA_W-1:0]  ext_wdata;
        logic [BYTES-1:0]   ext_wpar;
        logic               tag_src;
        logic [IDX_W-1:0]   tag_idx;
        logic               tag_last;
    } iss_t;

    iss_t        s_q, s_d;
    logic        open_w;
    logic [2:0]  gnt_w;

    assign open_w = !s_q.busy && !s_q.gap;

    l2fill_arb #(.N(3)) arb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_i (open_w),
        .req_i  ({s_req, i_req, d_req}),
        .gnt_o  (gnt_w)
    );

    assign d_gnt = gnt_w[0];
    assign i_gnt = gnt_w[1];
    assign s_gnt = gnt_w[2];

    always_comb begin
        s_d        = s_q;
        s_d.ext_en = 1'b0;
        s_d.ext_we = 1'b0;
        s_d.gap    = 1'b0;

        if (s_q.busy && !s_q.gap) begin
            // next beat of a running fill
            s_d.ext_en   = 1'b1;
            s_d.ext_addr = s_q.base + (ADDR_W'(s_q.beat) << OFF_W);
            s_d.tag_src  = s_q.src;
            s_d.tag_idx  = s_q.beat;
            s_d.tag_last = (s_q.beat == s_q.last_idx);
            s_d.gap      = 1'b1;
            if (s_q.beat == s_q.last_idx) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.beat = s_q.beat + IDX_W'(1);
            end
        end else if (gnt_w[0] || gnt_w[1]) begin
            // new fill: first beat goes out at once
            s_d.src      = gnt_w[0] ? l2fill_pkg::SRC_DATA : l2fill_pkg::SRC_INST;
            s_d.base     = gnt_w[0] ? (d_addr & D_MASK) : (i_addr & I_MASK);
            s_d.last_idx = gnt_w[0] ? D_LAST : I_LAST;
            s_d.busy     = (s_d.last_idx != '0);
            s_d.beat     = IDX_W'(1);
            s_d.ext_en   = 1'b1;
            s_d.ext_addr = s_d.base;
            s_d.tag_src  = s_d.src;
            s_d.tag_idx  = '0;
            s_d.tag_last = (s_d.last_idx == '0);
            s_d.gap      = 1'b1;
        end else if (gnt_w[2]) begin
            // write-through store: a single beat, no wait for completion
            s_d.ext_en    = 1'b1;
            s_d.ext_we    = 1'b1;
            s_d.ext_addr  = s_addr & S_MASK;
            s_d.ext_wdata = s_data;
            s_d.gap       = 1'b1;
        end

        for (int b = 0; b < BYTES; b++) begin
            s_d.ext_wpar[b] = l2fill_pkg::even_bit(s_d.ext_wdata[8*b +: 8]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ext_en    = s_q.ext_en;
    assign ext_we    = s_q.ext_we;
    assign ext_addr  = s_q.ext_addr;
    assign ext_wdata = s_q.ext_wdata;
    assign ext_wpar  = s_q.ext_wpar;
    assign tag_vld   = s_q.ext_en && !s_q.ext_we;
    assign tag_src   = s_q.tag_src;
    assign tag_idx   = s_q.tag_idx;
    assign tag_last  = s_q.tag_last;

    AST_ISSUE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ext_en |=> !s_q.ext_en); // R1

    AST_NO_GNT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy || s_q.gap) |-> (gnt_w == '0)); // R6

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ext_en && !s_q.ext_we && s_q.tag_idx != '0) |->
        ($past(s_q.ext_en, 2) && s_q.ext_addr == $past(s_q.ext_addr, 2) + ADDR_W'(BYTES))); // R3

    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ext_en |-> (s_q.ext_addr[OFF_W-1:0] == '0)); // R4

endmodule

// File: rtl/l2fill_ret.sv
module l2fill_ret #(
    parameter int DATA_W  = 64,
    parameter int D_BEATS = 2,
    parameter int I_BEATS = 4,
    parameter int RD_LAT  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tag_vld,
    input  logic                       tag_src,
    input  logic [$clog2(I_BEATS)-1:0] tag_idx,
    input  logic                       tag_last,
    input  logic [DATA_W-1:0]          ext_rdata,
    input  logic [DATA_W/8-1:0]        ext_rpar,
    output logic                       fill_valid,
    output logic                       fill_src,
    output logic [$clog2(I_BEATS)-1:0] fill_idx,
    output logic                       fill_last,
    output logic [DATA_W-1:0]          fill_data,
    output logic                       fill_perr
);

    localparam int BYTES = DATA_W / 8;
    localparam int IDX_W = $clog2(I_BEATS);

    typedef struct packed {
        logic             vld;
        logic             src;
        logic [IDX_W-1:0] idx;
        logic             last;
    } tag_t;

    typedef struct packed {
        tag_t [RD_LAT-1:0] pipe;
        logic              vld;
        logic              src;
        logic [IDX_W-1:0]  idx;
        logic              last;
        logic [DATA_W-1:0] data;
        logic              perr;
    } ret_t;

    ret_t             r_q, r_d;
    tag_t             tail;
    logic [BYTES-1:0] byte_err;

    for (genvar b = 0; b < BYTES; b++) begin : g_par
        assign byte_err[b] = l2fill_pkg::even_bit(ext_rdata[8*b +: 8]) ^ ext_rpar[b];
    end

    assign tail = r_q.pipe[RD_LAT-1];

    always_comb begin
        r_d = r_q;
        r_d.pipe[0].vld  = tag_vld;
        r_d.pipe[0].src  = tag_src;
        r_d.pipe[0].idx  = tag_idx;
        r_d.pipe[0].last = tag_last;
        for (int k = 1; k < RD_LAT; k++) begin
            r_d.pipe[k] = r_q.pipe[k-1];
        end
        r_d.vld  = tail.vld;
        r_d.src  = tail.src;
        r_d.idx  = tail.idx;
        r_d.last = tail.last;
        r_d.data = ext_rdata;
        r_d.perr = tail.vld && (byte_err != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fill_valid = r_q.vld;
    assign fill_src   = r_q.src;
    assign fill_idx   = r_q.idx;
    assign fill_last  = r_q.last;
    assign fill_data  = r_q.data;
    assign fill_perr  = r_q.perr;

    AST_FILL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.vld && r_q.last) |->
        (r_q.idx == (r_q.src ? IDX_W'(I_BEATS - 1) : IDX_W'(D_BEATS - 1)))); // R8

    AST_FILL_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.vld && r_q.idx != '0) |->
        ($past(r_q.vld, 2) && $past(r_q.idx, 2) == r_q.idx - IDX_W'(1))); // R6

    AST_PERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.vld |-> !r_q.perr); // R9

endmodule

// File: rtl/l2fill_seq.sv
module l2fill_seq #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int D_BEATS = 2,
    parameter int I_BEATS = 4,
    parameter int RD_LAT  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dmiss_req,
    input  logic [ADDR_W-1:0]          dmiss_addr,
    output logic                       dmiss_gnt,
    input  logic                       imiss_req,
    input  logic [ADDR_W-1:0]          imiss_addr,
    output logic                       imiss_gnt,
    input  logic                       st_req,
    input  logic [ADDR_W-1:0]          st_addr,
    input  logic [DATA_W-1:0]          st_data,
    output logic                       st_gnt,
    output logic                       ext_en,
    output logic                       ext_we,
    output logic [ADDR_W-1:0]          ext_addr,
    output logic [DATA_W-1:0]          ext_wdata,
    output logic [DATA_W/8-1:0]        ext_wpar,
    input  logic [DATA_W-1:0]          ext_rdata,
    input  logic [DATA_W/8-1:0]        ext_rpar,
    output logic                       fill_valid,
    output logic                       fill_src,
    output logic [$clog2(I_BEATS)-1:0] fill_idx,
    output logic                       fill_last,
    output logic [DATA_W-1:0]          fill_data,
    output logic                       fill_perr
);

    localparam int IDX_W = $clog2(I_BEATS);

    logic             tag_vld_w;
    logic             tag_src_w;
    logic [IDX_W-1:0] tag_idx_w;
    logic             tag_last_w;

    l2fill_issue #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .D_BEATS (D_BEATS),
        .I_BEATS (I_BEATS)
    ) issue_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_req     (dmiss_req),
        .d_addr    (dmiss_addr),
        .i_req     (imiss_req),
        .i_addr    (imiss_addr),
        .s_req     (st_req),
        .s_addr    (st_addr),
        .s_data    (st_data),
        .d_gnt     (dmiss_gnt),
        .i_gnt     (imiss_gnt),
        .s_gnt     (st_gnt),
        .ext_en    (ext_en),
        .ext_we    (ext_we),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .ext_wpar  (ext_wpar),
        .tag_vld   (tag_vld_w),
        .tag_src   (tag_src_w),
        .tag_idx   (tag_idx_w),
        .tag_last  (tag_last_w)
    );

    l2fill_ret #(
        .DATA_W  (DATA_W),
        .D_BEATS (D_BEATS),
        .I_BEATS (I_BEATS),
        .RD_LAT  (RD_LAT)
    ) ret_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tag_vld    (tag_vld_w),
        .tag_src    (tag_src_w),
        .tag_idx    (tag_idx_w),
        .tag_last   (tag_last_w),
        .ext_rdata  (ext_rdata),
        .ext_rpar   (ext_rpar),
        .fill_valid (fill_valid),
        .fill_src   (fill_src),
        .fill_idx   (fill_idx),
        .fill_last  (fill_last),
        .fill_data  (fill_data),
        .fill_perr  (fill_perr)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!ext_en && !fill_valid)); // R10

endmodule

// File: tb/l2fill_seq_tb_top.sv
`timescale 1ns/1ps
module l2fill_seq_tb_top;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 64;
    localparam int D_BEATS = 2;
    localparam int I_BEATS = 4;
    localparam int RD_LAT  = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        dmiss_req, imiss_req, st_req;
    logic [31:0] dmiss_addr, imiss_addr, st_addr;
    logic [63:0] st_data;
    logic        dmiss_gnt, imiss_gnt, st_gnt;
    logic        ext_en, ext_we;
    logic [31:0] ext_addr;
    logic [63:0] ext_wdata, ext_rdata;
    logic [7:0]  ext_wpar, ext_rpar;
    logic        fill_valid, fill_src, fill_last, fill_perr;
    logic [1:0]  fill_idx;
    logic [63:0] fill_data;

    always #2 clk = ~clk;

    l2fill_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .D_BEATS(D_BEATS),
        .I_BEATS(I_BEATS), .RD_LAT(RD_LAT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .dmiss_req(dmiss_req), .dmiss_addr(dmiss_addr), .dmiss_gnt(dmiss_gnt),
        .imiss_req(imiss_req), .imiss_addr(imiss_addr), .imiss_gnt(imiss_gnt),
        .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .st_gnt(st_gnt),
        .ext_en(ext_en), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_wpar(ext_wpar),
        .ext_rdata(ext_rdata), .ext_rpar(ext_rpar),
        .fill_valid(fill_valid), .fill_src(fill_src), .fill_idx(fill_idx),
        .fill_last(fill_last), .fill_data(fill_data), .fill_perr(fill_perr)
    );

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [63:0] data;
        int          cyc;
        logic        src;
        int          idx;
        logic        last;
    } acc_t;

    typedef struct {
        logic perr;
        int   cyc;
    } ret_t;

    acc_t exp_acc[$];
    acc_t exp_fill[$];
    ret_t exp_ret[$];

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   free_cyc = 0;
    int   last_acc = -10;
    int   last_wr = -1;
    bit   done = 1'b0;
    bit   st_only = 1'b0;
    bit   burst = 1'b0;
    bit   rnd = 1'b0;
    int   rate = 3;
    bit   gd_p, gi_p, gs_p;
    // external memory model pipeline
    bit          m1_v, m2_v;
    logic [31:0] m1_a, m2_a;
    int          m1_c, m2_c;

    function automatic logic [63:0] mem_val(input logic [31:0] a);
        return {a ^ 32'hA5A5_0F0F, (a * 32'h9E37_79B1) ^ 32'h1234_5678};
    endfunction

    function automatic logic [7:0] par8(input logic [63:0] d);
        logic [7:0] p;
        for (int k = 0; k < 8; k++) p[k] = ^d[8*k +: 8];
        return p;
    endfunction

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic push_fill(input logic src, input logic [31:0] base, input int n, input int t);
        for (int k = 0; k < n; k++) begin
            acc_t e;
            e.we = 1'b0; e.addr = base + 32'(8 * k); e.data = '0;
            e.cyc = t + 1 + 2 * k; e.src = src; e.idx = k; e.last = (k == n - 1);
            exp_acc.push_back(e);
            exp_fill.push_back(e);
        end
    endtask

    task automatic step();
        acc_t e;
        ret_t r;
        string tg;
        int   n;
        bit   ed, ei, es;
        @(negedge clk);
        cyc++;
        // ---- returned beats
        if (fill_valid) begin
            if (exp_fill.size() == 0 || exp_ret.size() == 0) begin
                chk(1'b0, $sformatf("R8 unexpected fill beat got idx %0d exp none", fill_idx));
            end else begin
                e = exp_fill.pop_front();
                r = exp_ret.pop_front();
                tg = e.src ? "R3" : "R2";
                chk(fill_src == e.src && fill_idx == 2'(e.idx) && fill_last == e.last,
                    $sformatf("%s R8 beat tag got src%0d idx%0d last%0d exp src%0d idx%0d last%0d",
                              tg, fill_src, fill_idx, fill_last, e.src, e.idx, e.last));
                chk(fill_data == mem_val(e.addr),
                    $sformatf("%s fill data got %h exp %h", tg, fill_data, mem_val(e.addr)));
                chk(cyc == r.cyc, $sformatf("R8 return cycle got %0d exp %0d", cyc, r.cyc));
                chk(fill_perr == r.perr,
                    $sformatf("R9 parity flag got %0d exp %0d", fill_perr, r.perr));
            end
        end else if (exp_ret.size() != 0 && exp_ret[0].cyc <= cyc) begin
            chk(1'b0, $sformatf("R8 missing fill beat got none exp cycle %0d", exp_ret[0].cyc));
            void'(exp_ret.pop_front());
            if (exp_fill.size() != 0) void'(exp_fill.pop_front());
        end
        // ---- external accesses
        if (ext_en) begin
            chk(cyc - last_acc >= 2,
                $sformatf("R1 access spacing got %0d exp >=2", cyc - last_acc));
            if (exp_acc.size() == 0) begin
                chk(1'b0, $sformatf("R6 unexpected access got addr %h exp none", ext_addr));
            end else begin
                e = exp_acc.pop_front();
                tg = e.we ? "R4" : (e.src ? "R3" : "R2");
                chk(ext_we == e.we && ext_addr == e.addr,
                    $sformatf("%s access got we%0d addr %h exp we%0d addr %h",
                              tg, ext_we, ext_addr, e.we, e.addr));
                chk(cyc == e.cyc, $sformatf("R6 access cycle got %0d exp %0d", cyc, e.cyc));
                if (e.we) begin
                    chk(ext_wdata == e.data,
                        $sformatf("R4 write data got %h exp %h", ext_wdata, e.data));
                    chk(ext_wpar == par8(ext_wdata),
                        $sformatf("R5 write parity got %h exp %h", ext_wpar, par8(ext_wdata)));
                end
            end
            if (ext_we && st_only) begin
                if (last_wr >= 0)
                    chk(cyc - last_wr == 2,
                        $sformatf("R4 back-to-back store spacing got %0d exp 2", cyc - last_wr));
                last_wr = cyc;
            end
            last_acc = cyc;
        end else if (exp_acc.size() != 0 && exp_acc[0].cyc <= cyc) begin
            chk(1'b0, $sformatf("R6 missing access got none exp addr %h", exp_acc[0].addr));
            void'(exp_acc.pop_front());
        end
        // ---- memory model: return data RD_LAT cycles after the access
        if (m2_v) begin
            logic [63:0] d;
            logic [7:0]  p;
            bit          inj;
            d   = mem_val(m2_a);
            p   = par8(d);
            inj = ($urandom % 6 == 0);
            if (inj) p = p ^ (8'd1 << ($urandom % 8));
            ext_rdata = d;
            ext_rpar  = p;
            r.perr = inj;
            r.cyc  = m2_c + RD_LAT + 1;
            exp_ret.push_back(r);
        end else begin
            ext_rdata = '0;
            ext_rpar  = '0;
        end
        m2_v = m1_v; m2_a = m1_a; m2_c = m1_c;
        m1_v = ext_en && !ext_we; m1_a = ext_addr; m1_c = cyc;
        // ---- stimulus
        if (gd_p) dmiss_req = 1'b0;
        if (gi_p) imiss_req = 1'b0;
        if (gs_p) st_req = 1'b0;
        if (burst) begin
            dmiss_req = 1'b1; dmiss_addr = 32'h0000_104C;
            imiss_req = 1'b1; imiss_addr = 32'h0000_2077;
            st_req = 1'b1; st_addr = 32'h0000_3005; st_data = 64'hDEAD_BEEF_0123_4567;
        end else if (st_only) begin
            if (!st_req) begin
                st_req = 1'b1; st_addr = $urandom; st_data = {$urandom, $urandom};
            end
        end else if (rnd) begin
            if (!dmiss_req && ($urandom % rate == 0)) begin
                dmiss_req = 1'b1; dmiss_addr = $urandom;
            end
            if (!imiss_req && ($urandom % rate == 0)) begin
                imiss_req = 1'b1; imiss_addr = $urandom;
            end
            if (!st_req && ($urandom % rate == 0)) begin
                st_req = 1'b1; st_addr = $urandom; st_data = {$urandom, $urandom};
            end
        end
        #1;
        // ---- grants
        n = int'(dmiss_gnt) + int'(imiss_gnt) + int'(st_gnt);
        if (dmiss_req || imiss_req || st_req) begin
            if (cyc < free_cyc) begin
                chk(n == 0, $sformatf("R6 grant during fill got %0d exp 0", n));
            end else begin
                ed = dmiss_req;
                ei = !dmiss_req && imiss_req;
                es = !dmiss_req && !imiss_req && st_req;
                chk(dmiss_gnt == ed && imiss_gnt == ei && st_gnt == es,
                    $sformatf("R7 grant got d%0d i%0d s%0d exp d%0d i%0d s%0d",
                              dmiss_gnt, imiss_gnt, st_gnt, ed, ei, es));
            end
        end
        if (dmiss_gnt) begin
            push_fill(1'b0, dmiss_addr & ~32'hF, D_BEATS, cyc);
            free_cyc = cyc + 2 * D_BEATS;
        end else if (imiss_gnt) begin
            push_fill(1'b1, imiss_addr & ~32'h1F, I_BEATS, cyc);
            free_cyc = cyc + 2 * I_BEATS;
        end else if (st_gnt) begin
            e.we = 1'b1; e.addr = st_addr & ~32'h7; e.data = st_data;
            e.cyc = cyc + 1; e.src = 1'b0; e.idx = 0; e.last = 1'b1;
            exp_acc.push_back(e);
            free_cyc = cyc + 2;
        end
        gd_p = dmiss_gnt; gi_p = imiss_gnt; gs_p = st_gnt;
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0;
        dmiss_req = 1'b0; imiss_req = 1'b0; st_req = 1'b0;
        dmiss_addr = '0; imiss_addr = '0; st_addr = '0; st_data = '0;
        ext_rdata = '0; ext_rpar = '0;
        gd_p = 1'b0; gi_p = 1'b0; gs_p = 1'b0;
        m1_v = 1'b0; m2_v = 1'b0; m1_a = '0; m2_a = '0; m1_c = 0; m2_c = 0;
        repeat (4) step();
        chk(!ext_en && !fill_valid,
            $sformatf("R10 reset state got en%0d fv%0d exp 0 0", ext_en, fill_valid));
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk(!ext_en && !fill_valid,
                $sformatf("R10 idle after reset got en%0d fv%0d exp 0 0", ext_en, fill_valid));
        end
        // directed: saturated store stream (R4)
        st_only = 1'b1;
        repeat (14) step();
        st_only = 1'b0;
        repeat (10) step();
        // directed: all three requests at once (R7, R2, R3)
        burst = 1'b1;
        step();
        burst = 1'b0;
        repeat (24) step();
        // random mix, then fully loaded
        rnd = 1'b1;
        rate = 3;
        repeat (3000) step();
        rate = 1;
        repeat (500) step();
        rnd = 1'b0;
        repeat (40) step();
        chk(exp_acc.size() == 0 && exp_fill.size() == 0 && exp_ret.size() == 0,
            $sformatf("R6 leftover expectations got %0d/%0d/%0d exp 0/0/0",
                      exp_acc.size(), exp_fill.size(), exp_ret.size()));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d exp completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule